// File: doc/BRIEF.md
# Sequence-Numbered Flit Replay Buffer

This block sits on the transmit side of a flit link. It gives each outgoing flit a sequence number and forwards it to the output stream in the same cycle. A copy of the flit stays in a circular store until the far end acknowledges it. Every kind of protocol flit is treated the same way: I/O, cache/memory and link-management traffic all get numbers and all are kept.

An acknowledgement is cumulative. A number that falls inside the outstanding window releases that entry and every entry older than it. A negative acknowledgement asks for a retransmission in one of two ways. In standard mode the block goes back to the oldest unacknowledged flit and resends every held flit in order. In selective mode it resends only the named flit, placed ahead of the next new flit. While a retransmission is pending or running, new input is held off.

Sequence numbers wrap at 2^SEQ_W, which is 1024 by default. Arithmetic on the window therefore works modulo that size. Acknowledgement numbers that fall outside the window are dropped, and the block raises a one-cycle error flag.

Top module: `flit_replay_buf`

## Requirements
- R1: After reset, new flits get the numbers 0, 1, 2, ... in order, wrapping from 1023 to 0. A new flit appears on the output in the cycle it is accepted, with out_seq set to its number and out_replay=0.
- R2: When DEPTH flits are unacknowledged, in_ready is 0 and no new flit reaches the output.
- R3: An ack (ack_nack=0) with number s inside the window releases every flit up to and including s. This works across the wrap point, and released room makes in_ready 1 again.
- R4: A standard nack (ack_nack=1, ack_sel=0) with a number inside the window makes the block resend every held flit, oldest first through newest. Each resent flit carries out_replay=1 and its original number and data. New traffic resumes afterwards.
- R5: in_ready stays 0 while a retransmission is pending or running.
- R6: A selective nack (ack_nack=1, ack_sel=1) resends only the named flit, once, before the next new flit. It releases nothing: a later standard replay still starts at the oldest held flit.
- R7: An ack or nack whose number lies outside the outstanding window changes no state. In the cycle after it, seq_err is 1 for exactly one cycle.
- R8: During reset and right after it, out_valid=0 and seq_err=0, and in_ready follows out_ready.
- R9: An ack that arrives during a standard replay and covers flits not yet resent makes the replay skip those flits. The replay continues from the first flit that is still unacknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | New flit offered |
| in_ready | output | 1 | New flit accepted this cycle when in_valid is 1 |
| in_data | input | W | New flit payload |
| out_valid | output | 1 | Output flit present |
| out_ready | input | 1 | Link takes the output flit |
| out_data | output | W | Output flit payload |
| out_seq | output | SEQ_W | Sequence number of the output flit |
| out_replay | output | 1 | 1 when the output flit is a retransmission |
| ack_valid | input | 1 | Acknowledgement event present |
| ack_nack | input | 1 | 0 = ack, 1 = nack |
| ack_sel | input | 1 | For a nack: 1 = selective, 0 = standard |
| ack_seq | input | SEQ_W | Sequence number carried by the event |
| seq_err | output | 1 | One-cycle flag for an out-of-window event |

## Verification
New flits pass through combinationally. Their number and data are therefore checked in the same cycle they are offered, between the falling and the rising edge. Ack and nack events take effect at the rising edge that samples them, so head movement and the seq_err pulse are read just after that edge. The error flag is read once more one edge later, to confirm it is a one-cycle pulse. Retransmitted flits begin on the first falling edge after the nack has been registered. Each one is checked before the edge that consumes it, and in_ready is sampled in the same window.

// File: rtl/flit_replay_buf.sv
module flit_replay_buf #(
  parameter int W     = 32,
  parameter int DEPTH = 16,
  parameter int SEQ_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [W-1:0]     in_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [W-1:0]     out_data,
  output logic [SEQ_W-1:0] out_seq,
  output logic             out_replay,
  input  logic             ack_valid,
  input  logic             ack_nack,
  input  logic             ack_sel,
  input  logic [SEQ_W-1:0] ack_seq,
  output logic             seq_err
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [SEQ_W-1:0] DEPTH_S = SEQ_W'(DEPTH);

  initial assert (DEPTH >= 2 && (1 << AW) == DEPTH && DEPTH <= (1 << (SEQ_W - 1)))
    else $error("DEPTH must be a power of two between 2 and half the sequence space");

  logic [W-1:0]     mem [DEPTH];
  logic [SEQ_W-1:0] head, tail, rp, sel_seq;
  logic             rp_act, sel_pend;
  logic [SEQ_W-1:0] head_n, tail_n, rp_n, sel_seq_n;
  logic             rp_act_n, sel_pend_n;

  wire [SEQ_W-1:0] cnt      = tail - head;
  wire             full     = (cnt == DEPTH_S);
  wire [SEQ_W-1:0] a_off    = ack_seq - head;
  wire             in_win   = a_off < cnt;
  wire [SEQ_W-1:0] new_head = ack_seq + 1'b1;
  wire             do_ack   = ack_valid && !ack_nack && in_win;
  wire             do_std   = ack_valid && ack_nack && !ack_sel && in_win;
  wire             do_sel   = ack_valid && ack_nack && ack_sel && in_win;
  wire [SEQ_W-1:0] rd_seq   = rp_act ? rp : sel_seq;

  assign out_replay = rp_act || sel_pend;
  assign out_valid  = out_replay || (in_valid && !full);
  assign out_seq    = out_replay ? rd_seq : tail;
  assign out_data   = out_replay ? mem[rd_seq[AW-1:0]] : in_data;
  assign in_ready   = out_ready && !full && !out_replay;

  wire in_fire  = in_valid && in_ready;
  wire rp_fire  = rp_act && out_ready;
  wire sel_fire = !rp_act && sel_pend && out_ready;

  always_ff @(posedge clk)
    if (in_fire) mem[tail[AW-1:0]] <= in_data;

  always_comb begin
    head_n     = head;
    tail_n     = tail + SEQ_W'(in_fire);
    rp_n       = rp + SEQ_W'(rp_fire);
    sel_seq_n  = sel_seq;
    sel_pend_n = sel_pend && !sel_fire;
    if (do_ack) begin
      head_n = new_head;
      if (rp_act && (rp_n - head) < (new_head - head)) rp_n = new_head;
      if (sel_pend_n && (sel_seq - head) < (new_head - head)) sel_pend_n = 1'b0;
    end
    rp_act_n = rp_act && (rp_n != tail);
    if (do_std) begin
      rp_n       = head;
      rp_act_n   = 1'b1;
      sel_pend_n = 1'b0;
    end
    if (do_sel) begin
      sel_seq_n  = ack_seq;
      sel_pend_n = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      head <= '0; tail <= '0; rp <= '0; sel_seq <= '0;
      rp_act <= 1'b0; sel_pend <= 1'b0; seq_err <= 1'b0;
    end else begin
      head <= head_n; tail <= tail_n; rp <= rp_n; sel_seq <= sel_seq_n;
      rp_act <= rp_act_n; sel_pend <= sel_pend_n;
      seq_err <= ack_valid && !in_win;
    end

  a_r1_seq_step: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> tail == $past(tail) + 1'b1);
  a_r2_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    (tail - head) <= DEPTH_S);
  a_r3_release: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_valid && !ack_nack && in_win) |=> head == $past(ack_seq) + 1'b1);
  a_r5_hold_input: assert property (@(posedge clk) disable iff (!rst_n)
    out_replay |-> !in_ready);
  a_r6_nack_keeps_head: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_valid && ack_nack) |=> head == $past(head));
  a_r7_err_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_valid && !in_win) |=> seq_err && head == $past(head));
endmodule

// File: tb/flit_replay_buf_tb.sv
module flit_replay_buf_tb;
  localparam int PERIOD = 10;
  localparam int W = 32, DEPTH = 16, SEQ_W = 10;

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, out_ready = 1, ack_valid = 0, ack_nack = 0, ack_sel = 0;
  logic [W-1:0] in_data = '0;
  logic [SEQ_W-1:0] ack_seq = '0;
  logic in_ready, out_valid, out_replay, seq_err;
  logic [W-1:0] out_data;
  logic [SEQ_W-1:0] out_seq;

  int tests = 0, fails = 0, tail_m = 0;

  always #(PERIOD/2) clk = ~clk;

  flit_replay_buf #(.W(W), .DEPTH(DEPTH), .SEQ_W(SEQ_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_seq(out_seq),
    .out_replay(out_replay), .ack_valid(ack_valid), .ack_nack(ack_nack), .ack_sel(ack_sel),
    .ack_seq(ack_seq), .seq_err(seq_err));

  // vector: {op[1:0], arg[9:0], exp_err}; op 0 = send, 1 = ack, 2 = standard nack
  localparam logic [12:0] VEC [11] = '{
    {2'd0, 10'd0, 1'b0}, {2'd0, 10'd0, 1'b0}, {2'd0, 10'd0, 1'b0},
    {2'd0, 10'd0, 1'b0}, {2'd0, 10'd0, 1'b0},
    {2'd1, 10'd2, 1'b0}, {2'd1, 10'd1, 1'b1}, {2'd1, 10'd9, 1'b1},
    {2'd0, 10'd0, 1'b0}, {2'd1, 10'd5, 1'b0}, {2'd2, 10'd6, 1'b1}};

  function automatic logic [W-1:0] dat(int s);
    return 32'hC0DE_0000 | W'(s % 1024);
  endfunction

  task automatic chk(bit ok, string req, longint act, longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send();
    @(negedge clk);
    in_valid = 1; in_data = dat(tail_m); out_ready = 1;
    #1 chk(out_valid && in_ready && !out_replay && out_seq == SEQ_W'(tail_m % 1024)
           && out_data == dat(tail_m), "R1 new flit numbering", out_seq, tail_m % 1024);
    @(posedge clk); #1 in_valid = 0;
    tail_m++;
  endtask

  task automatic evt(bit nack, bit sel, int s, bit exp_err, string req);
    @(negedge clk);
    ack_valid = 1; ack_nack = nack; ack_sel = sel; ack_seq = SEQ_W'(s % 1024);
    @(posedge clk); #1 ack_valid = 0;
    chk(seq_err == exp_err, req, seq_err, exp_err);
    if (exp_err) begin
      @(posedge clk); #1 chk(!seq_err, "R7 error is one pulse", seq_err, 0);
    end
  endtask

  task automatic expect_rep(int s, string req);
    @(negedge clk);
    out_ready = 1; in_valid = 1; in_data = 32'hDEAD_BEEF;
    #1 chk(out_valid && out_replay && !in_ready && out_seq == SEQ_W'(s % 1024)
           && out_data == dat(s), req, out_seq, s % 1024);
    in_valid = 0;
    @(posedge clk); #1;
  endtask

  initial begin
    #(PERIOD * 200000);
    fails++; tests++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    // R8 reset state
    #(PERIOD*2 + 1);
    chk(!out_valid && !seq_err && in_ready, "R8 during reset", {out_valid, seq_err, in_ready}, 3'b001);
    @(negedge clk); rst_n = 1;
    #1 chk(!out_valid && !seq_err && in_ready, "R8 after reset", {out_valid, seq_err, in_ready}, 3'b001);

    // vector table: numbering, cumulative ack, window errors
    foreach (VEC[i]) begin
      case (VEC[i][12:11])
        2'd0: send();
        2'd1: evt(0, 0, int'(VEC[i][10:1]), VEC[i][0], "R3/R7 ack window");
        default: evt(1, 0, int'(VEC[i][10:1]), VEC[i][0], "R7 nack on empty");
      endcase
    end

    // R2 full buffer
    for (int i = 0; i < DEPTH; i++) send();
    @(negedge clk); in_valid = 1; in_data = 32'h1;
    #1 chk(!in_ready && !out_valid, "R2 full holds input", {in_ready, out_valid}, 0);
    in_valid = 0;
    evt(0, 0, 9, 0, "R3 ack frees four");
    @(negedge clk); #1 chk(in_ready, "R3 room after ack", in_ready, 1);

    // R4 / R5 standard replay of 10..21
    evt(1, 0, 12, 0, "R4 standard nack accepted");
    for (int s = 10; s < 22; s++) expect_rep(s, "R4 R5 standard replay order");
    @(negedge clk); #1 chk(in_ready && !out_replay, "R4 traffic resumes", in_ready, 1);

    // R6 selective replay
    evt(1, 1, 15, 0, "R6 selective nack accepted");
    expect_rep(15, "R6 selective flit first");
    send();
    @(negedge clk); #1 chk(!out_valid, "R6 single resend", out_valid, 0);
    evt(1, 0, 11, 0, "R6 standard nack after selective");
    expect_rep(10, "R6 ack state unchanged");
    expect_rep(11, "R4 replay continues");

    // R9 ack during replay skips covered flits
    @(negedge clk); out_ready = 0;
    evt(0, 0, 17, 0, "R9 ack during replay");
    for (int s = 18; s < 23; s++) expect_rep(s, "R9 replay skips acked");
    @(negedge clk); #1 chk(in_ready && !out_replay, "R5 input released", in_ready, 1);
    evt(0, 0, 22, 0, "R3 ack all");

    // R1 / R3 wrap of the sequence space
    for (int i = 0; i < 1005; i++) begin
      send();
      if (i % 8 == 7) evt(0, 0, tail_m - 1, 0, "R3 ack near wrap");
    end
    evt(0, 0, tail_m - 1, 0, "R3 ack across wrap");
    evt(1, 0, tail_m - 1, 1, "R7 nack after full release");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule